// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block sets the timing of the serial clock for an I2C master that runs from a fast peripheral clock. A prescaler divides the input clock by a power of two to make a base tick. The clock then alternates between a driven-low phase and a released-high phase, and each phase lasts a programmed number of ticks. The high phase counts a tick only while the sensed SCL level is high, so a slave that holds the clock low lengthens the high phase instead of shortening it.

A byte engine sits beside this block. It uses two one-cycle strobes: one in the middle of the low phase, where SDA may be changed, and one in the middle of the high phase, where SDA is sampled. Timing comes from a packed 32-bit configuration word. Only the prescaler exponent and the two phase counts are read from it; all other bits belong to neighbouring logic. Deasserting the enable input returns the block to an idle state with SCL released.

Top module: `scl_timing_gen`

## Requirements
- R1: During and after reset, with enable low, `phase` reads 0, `scl_drive_low` is 0, and `tick`, `mid_low` and `mid_high` are 0.
- R2: While `phase` is not 0, `tick` pulses for one cycle every 2^E input cycles, where E = `cfg[3:0]`. The first pulse comes 2^E cycles after the phase first becomes low.
- R3: The low phase (`phase` = 1, `scl_drive_low` = 1) lasts (L+1)·2^E cycles, where L = `cfg[15:12]`.
- R4: With no stretching, the high phase (`phase` = 2) lasts (H+1)·2^E cycles, where H = `cfg[19:16]`. A full SCL period is therefore L+H+2 ticks.
- R5: A tick that falls in the high phase while `scl_in` is low is not counted. A stretch of S cycles, where S is a multiple of 2^E, lengthens the high phase to S+(H+1)·2^E cycles and delays its mid strobe by S.
- R6: `mid_low` pulses exactly once per low phase, on low-phase tick number (L>>1)+1. That is at cycle offset ((L>>1)+1)·2^E−1 from the start of the phase.
- R7: `mid_high` pulses exactly once per high phase, on counted tick number (H>>1)+1, and only while `scl_in` is high. No strobe appears outside its own phase.
- R8: When `en` is sampled low, `phase` becomes 0 at that clock edge, SCL is released and no tick or strobe is produced. When `en` is raised again, timing restarts from a complete low phase.
- R9: `phase` uses the encoding 0 = off, 1 = low, 2 = high, and never reads 3. `scl_drive_low` is high exactly when `phase` is 1. The phases alternate low, high, low.
- R10: Configuration bits 31:20 and 11:4 have no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the SCL timing; low forces idle |
| cfg | input | 32 | Timing word: exponent [3:0], low count [15:12], high count [19:16] |
| scl_in | input | 1 | Sensed SCL line level |
| tick | output | 1 | Base tick strobe |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| phase | output | 2 | 0 off, 1 low, 2 high |
| mid_low | output | 1 | Strobe in the middle of the low phase |
| mid_high | output | 1 | Strobe in the middle of the high phase |

## Verification
The bench drives counts of zero, where each phase lasts a single tick and the mid strobe must fall on that same tick. A design with an off-by-one bias would give phases one tick short or long, or would miss the strobe entirely. Slave stretching is modelled by holding `scl_in` low at the start of each high phase. A design that counts stretched ticks would end the high phase early and place its mid strobe while the line is still low. The bench also drops enable in the middle of a phase and then restarts: a prescaler that is not cleared would make the first low phase after the restart short. Finally, a run with every unused configuration bit set to one catches any decoding of the wrong field.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int CFG_W    = 32;
    localparam int EXP_W    = 4;
    localparam int PH_CNT_W = 4;
    localparam int EXP_LSB  = 0;
    localparam int LOW_LSB  = 12;
    localparam int HIGH_LSB = 16;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic [EXP_W-1:0]    exp;
        logic [PH_CNT_W-1:0] low_n;
        logic [PH_CNT_W-1:0] high_n;
    } scl_timing_t;

    function automatic scl_timing_t unpack_timing(input logic [CFG_W-1:0] w);
        scl_timing_t t;
        t.exp    = w[EXP_LSB  +: EXP_W];
        t.low_n  = w[LOW_LSB  +: PH_CNT_W];
        t.high_n = w[HIGH_LSB +: PH_CNT_W];
        return t;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [EXP_W-1:0] exp,
    output logic             tick
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // 2^exp - 1 formed as the complement of a shifted all-ones mask
    assign limit = ~({CNT_W{1'b1}} << exp);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = PH_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_n,
    input  logic [CNT_W-1:0] high_n,
    output scl_phase_e       phase,
    output logic             mid_low,
    output logic             mid_high
);
    scl_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             high_adv;

    // a high-phase tick counts only once the line is seen released
    assign high_adv = tick && scl_in;
    assign phase    = phase_q;
    assign mid_low  = tick && (phase_q == PH_LOW) && (cnt_q == (low_n >> 1));
    assign mid_high = high_adv && (phase_q == PH_HIGH) && (cnt_q == (high_n >> 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_OFF: begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                end
                PH_LOW: begin
                    if (tick) begin
                        if (cnt_q == low_n) begin
                            phase_q <= PH_HIGH;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (high_adv) begin
                        if (cnt_q == high_n) begin
                            phase_q <= PH_LOW;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    phase_q <= PH_OFF;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] cfg,
    input  logic        scl_in,
    output logic        tick,
    output logic        scl_drive_low,
    output logic [1:0]  phase,
    output logic        mid_low,
    output logic        mid_high
);
    scl_timing_t timing;
    scl_phase_e  phase_s;
    logic        run;
    logic        unused_cfg;

    assign timing     = unpack_timing(cfg);
    assign unused_cfg = ^{cfg[31:20], cfg[11:4]};
    assign run        = (phase_s != PH_OFF);

    scl_prescaler #(
        .EXP_W (EXP_W)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .exp  (timing.exp),
        .tick (tick)
    );

    scl_phase_ctrl #(
        .CNT_W (PH_CNT_W)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .scl_in   (scl_in),
        .low_n    (timing.low_n),
        .high_n   (timing.high_n),
        .phase    (phase_s),
        .mid_low  (mid_low),
        .mid_high (mid_high)
    );

    assign phase         = phase_s;
    assign scl_drive_low = (phase_s == PH_LOW);

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       scl_in,
    input logic       tick,
    input logic [1:0] phase,
    input logic       mid_low,
    input logic       mid_high
);
    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) |-> !tick); // R8

    AST_EN_LOW_STOPS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase == 2'd0)); // R8

    AST_OFF_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && en) |=> (phase == 2'd1)); // R8

    AST_LEGAL_PHASE: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3); // R9

    AST_LOW_EXIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1 && en && !tick) |=> (phase == 2'd1)); // R3

    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && en && !scl_in) |=> (phase == 2'd2)); // R5

    AST_MID_LOW_PLACE: assert property (@(posedge clk) disable iff (rst)
        mid_low |-> (tick && phase == 2'd1)); // R6

    AST_MID_HIGH_PLACE: assert property (@(posedge clk) disable iff (rst)
        mid_high |-> (tick && scl_in && phase == 2'd2)); // R7

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .scl_in   (scl_in),
    .tick     (tick),
    .phase    (phase),
    .mid_low  (mid_low),
    .mid_high (mid_high)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

    typedef struct {
        int    kind;
        int    len;
        int    mid;
        string tag_len;
        string tag_mid;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] cfg = '0;
    logic        scl_in;
    logic        tick, scl_drive_low, mid_low, mid_high;
    logic [1:0]  phase;

    int checks = 0;
    int fails  = 0;
    int cur_e  = 0;
    int stretch = 0;
    int hcyc   = 0;
    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    scl_timing_gen dut (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .cfg           (cfg),
        .scl_in        (scl_in),
        .tick          (tick),
        .scl_drive_low (scl_drive_low),
        .phase         (phase),
        .mid_low       (mid_low),
        .mid_high      (mid_high)
    );

    // slave model: holds the line low for `stretch` cycles of each high phase
    always @(posedge clk) begin
        if (phase != 2'd2) hcyc <= 0;
        else               hcyc <= hcyc + 1;
    end
    assign scl_in = (phase == 2'd1) ? 1'b0 :
                    ((phase == 2'd2) ? (hcyc >= stretch) : 1'b1);

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int e, input int l, input int h, input bit junk);
        logic [31:0] w;
        w = junk ? 32'hFFF0_0FF0 : 32'h0;
        w[3:0]   = e[3:0];
        w[15:12] = l[3:0];
        w[19:16] = h[3:0];
        return w;
    endfunction

    // monitor
    int cur_ph = 0, run_len = 0, mid_at = -1, mid_n = 0, gap = 0;
    int bad_enc = 0, wrong_mid = 0;
    bit seg_ok = 0;

    task automatic score(input int kind, input int len, input int at, input int n);
        exp_item_t it;
        if (exp_q.size() == 0) return;
        it = exp_q.pop_front();
        chk(it.kind == kind, "R9", kind, it.kind);
        chk(len == it.len, it.tag_len, len, it.len);
        chk(n == 1, it.tag_mid, n, 1);
        chk(at == it.mid, it.tag_mid, at, it.mid);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            cur_ph = 0; seg_ok = 0; gap = 0;
        end else begin
            if (int'(phase) != cur_ph) begin
                if (seg_ok && ((cur_ph == 1 && phase == 2'd2) || (cur_ph == 2 && phase == 2'd1)))
                    score(cur_ph, run_len, mid_at, mid_n);
                seg_ok  = (phase != 2'd0);
                cur_ph  = int'(phase);
                run_len = 0; mid_at = -1; mid_n = 0;
            end
            if (phase == 2'd0) gap = 0;
            else begin
                gap++;
                if (tick) begin
                    chk(gap == (1 << cur_e), "R2", gap, 1 << cur_e);
                    gap = 0;
                end
            end
            if ((mid_low && phase != 2'd1) || (mid_high && phase != 2'd2)) wrong_mid++;
            if ((mid_low && phase == 2'd1) || (mid_high && phase == 2'd2)) begin
                mid_n++;
                mid_at = run_len;
            end
            run_len++;
            if ((scl_drive_low != (phase == 2'd1)) || phase == 2'd3) bad_enc++;
        end
    end

    // driver: pushes expected phase items, then lets the design run
    task automatic run_cfg(input int e, input int l, input int h, input int s,
                           input int periods, input bit junk);
        exp_item_t lo, hi;
        int p2;
        en = 1'b0;
        repeat (3) @(negedge clk);
        p2 = 1 << e;
        cfg = mk_cfg(e, l, h, junk);
        cur_e = e;
        stretch = s;
        lo.kind = 1; lo.len = (l + 1) * p2; lo.mid = ((l >> 1) + 1) * p2 - 1;
        lo.tag_len = junk ? "R10" : "R3";
        lo.tag_mid = junk ? "R10" : "R6";
        hi.kind = 2; hi.len = s + (h + 1) * p2; hi.mid = s + ((h >> 1) + 1) * p2 - 1;
        hi.tag_len = junk ? "R10" : ((s != 0) ? "R5" : "R4");
        hi.tag_mid = junk ? "R10" : ((s != 0) ? "R5" : "R7");
        for (int i = 0; i < periods; i++) begin
            exp_q.push_back(lo);
            exp_q.push_back(hi);
        end
        en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int seen;
        repeat (4) @(negedge clk);
        // R1 during reset
        chk(phase == 2'd0 && !scl_drive_low, "R1", int'(phase), 0);
        chk(!tick && !mid_low && !mid_high, "R1", int'(tick), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(phase == 2'd0 && !scl_drive_low && !tick, "R1", int'(phase), 0);

        run_cfg(0, 3, 3, 0, 3, 1'b0);
        run_cfg(2, 5, 2, 0, 2, 1'b0);
        run_cfg(1, 0, 0, 0, 4, 1'b0);   // zero counts: one tick per phase
        run_cfg(3, 7, 7, 16, 2, 1'b0);  // R5 stretch of two ticks
        run_cfg(0, 4, 6, 5, 2, 1'b0);   // R5 stretch with undivided tick
        run_cfg(4, 15, 15, 0, 1, 1'b0);
        run_cfg(1, 2, 4, 0, 2, 1'b1);   // R10 unused bits all set

        // R8: drop enable in the middle of a low phase
        en = 1'b0;
        repeat (3) @(negedge clk);
        cfg = mk_cfg(2, 7, 7, 1'b0);
        cur_e = 2;
        stretch = 0;
        en = 1'b1;
        repeat (10) @(negedge clk);
        chk(phase == 2'd1, "R8", int'(phase), 1);
        en = 1'b0;
        @(negedge clk);
        chk(phase == 2'd0, "R8", int'(phase), 0);
        chk(!scl_drive_low && !tick, "R8", int'(scl_drive_low), 0);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick || mid_low || mid_high || phase != 2'd0) seen++;
        end
        chk(seen == 0, "R8", seen, 0);
        // restart must begin from a complete low phase
        run_cfg(2, 3, 1, 0, 2, 1'b0);

        chk(bad_enc == 0, "R9", bad_enc, 0);
        chk(wrong_mid == 0, "R7", wrong_mid, 0);
        summary();
        $finish;
    end

endmodule